// File: doc/BRIEF.md
# Audio Serial Clock Prescaler

This block derives all timing for an audio serial port from one audio source clock. A linear prescaler divides the source clock by `2*DIV + ODD`, so both even and odd ratios are available. When the master clock output is turned on, the prescaler output drives that pin directly. A bit clock is then made from it by a further fixed division of 4 (32-bit channels) or 8 (16-bit channels). When the master clock is off, the prescaler output is itself the bit clock. A frame counter driven by bit-clock rising edges produces a single-cycle frame strobe. The frame is two channels long in I2S format and one channel long in PCM format.

All logic runs on the source clock. Every output toggles from a register clocked by that clock, and no derived clock drives a flop. The configuration is captured on every clock edge while the generator is disabled. It is held frozen while the generator runs, and while disabled every output is low. Divider values 0 and 1 are not valid settings and select a fixed divide-by-2.

Top module: `audio_clkgen`

## Requirements
- R1: While `gen_en` is low, or while `rst_n` is low, `mclk_out`, `bclk_out` and `frame_stb` are all 0 from the next rising edge of `clk_src` onward.
- R2: With `div_val` ≥ 2, the prescaler period N is `2*div_val + odd_ext` source cycles. With `mclk_en`=1 this is the period of `mclk_out`.
- R3: Each prescaler period is high for `N - floor(N/2)` cycles and low for `floor(N/2)` cycles, so the phases differ by at most one cycle.
- R4: With `div_val` of 0 or 1, N is 2 and `odd_ext` has no effect.
- R5: With `mclk_en`=1, `bclk_out` has period 8·N when `chan32`=0 and 4·N when `chan32`=1, and is high for half of that period.
- R6: With `mclk_en`=0, `mclk_out` stays 0 and `bclk_out` has period N with the high/low split of R3.
- R7: With `mclk_en`=1, `frame_stb` repeats every 256·N cycles when `pcm_mode`=0 (I2S) and every 128·N cycles when `pcm_mode`=1 (PCM).
- R8: With `mclk_en`=0, `frame_stb` repeats every 32·(`chan32`+1)·N cycles in I2S and every 16·(`chan32`+1)·N cycles in PCM.
- R9: `frame_stb` is high for exactly one source cycle per frame.
- R10: Changes to `div_val`, `odd_ext`, `mclk_en`, `pcm_mode` and `chan32` while `gen_en` is high have no effect. The values present on the last clock edge with `gen_en` low are used until the generator is disabled again.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk_src | input | 1 | Audio source clock; all logic runs on it |
| rst_n | input | 1 | Synchronous active-low reset |
| gen_en | input | 1 | Generator run enable; configuration is captured while low |
| div_val | input | DIV_W | Prescaler divider value DIV |
| odd_ext | input | 1 | Adds one source cycle to the prescaler period |
| mclk_en | input | 1 | 1: drive master clock and derive bit clock from it |
| pcm_mode | input | 1 | 0: I2S two-channel frame, 1: PCM one-channel frame |
| chan32 | input | 1 | 0: 16-bit channel, 1: 32-bit channel |
| mclk_out | output | 1 | Master clock |
| bclk_out | output | 1 | Bit clock |
| frame_stb | output | 1 | One-cycle pulse at the start of each frame |

## Verification
The hardest case to reach from the ports is a configuration change that arrives while the generator is running. It should leave every output undisturbed, yet it shows up only as a period that fails to change. The stimulus starts the generator with one divider and alters `div_val` mid-run. It checks that the master clock period keeps its old value, then disables and re-enables the generator and checks that the new period appears. The full sweep crosses divider values, including the illegal 0 and 1, with the odd bit, the master clock switch, both formats and both channel lengths. For every combination it measures periods, high times and strobe width.

// File: rtl/audclk_pkg.sv
// Shared types for the audio serial clock prescaler.
// Assumes: configuration is static while the generator runs.
package audclk_pkg;

    typedef enum logic {
        FMT_I2S = 1'b0,
        FMT_PCM = 1'b1
    } frame_fmt_e;

    typedef struct packed {
        frame_fmt_e fmt;      // frame format
        logic       wide;     // 1: 32-bit channel
        logic       mclk_on;  // master clock driven
        logic       odd;      // odd-extension of the divider
    } mode_cfg_t;

endpackage

// File: rtl/audclk_prescaler.sv
// Linear prescaler: divides the source clock by 2*div+odd, or by 2 when
// div < 2. The output is high for the first ceil(N/2) cycles of each
// period. rise_o pulses in the first high cycle.
// Assumes: div and odd are stable while run is high.
module audclk_prescaler #(
    parameter int DIV_W = 8
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             run,
    input  logic [DIV_W-1:0] div,
    input  logic             odd,
    output logic             pre_clk_o,
    output logic             rise_o
);
    localparam int CNT_W = DIV_W + 1;

    logic [CNT_W-1:0] period;
    logic [CNT_W-1:0] hi_len;
    logic [CNT_W-1:0] cnt;

    // Purpose: period length and high-phase length from the divider.
    always_comb begin
        if (div >= DIV_W'(2)) begin
            period = {div, 1'b0} + CNT_W'(odd);
        end else begin
            period = CNT_W'(2);
        end
        hi_len = period - (period >> 1);
    end

    // Purpose: cycle counter and registered output phase.
    always_ff @(posedge clk) begin
        if (!rst_n || !run) begin
            cnt       <= '0;
            pre_clk_o <= 1'b0;
            rise_o    <= 1'b0;
        end else begin
            pre_clk_o <= (cnt < hi_len);
            rise_o    <= (cnt == '0);
            if (cnt == period - CNT_W'(1)) begin
                cnt <= '0;
            end else begin
                cnt <= cnt + CNT_W'(1);
            end
        end
    end

endmodule

// File: rtl/audclk_bitdiv.sv
// Bit-clock divider: counts prescaler rise ticks and produces a bit clock
// at 1/NARROW_DIV (16-bit channels) or 1/WIDE_DIV (32-bit channels) of the
// master clock rate, with a 50% duty cycle in master clock periods.
// Assumes: both ratios are even, and wide is stable while run is high.
module audclk_bitdiv #(
    parameter int NARROW_DIV = 8,
    parameter int WIDE_DIV   = 4
) (
    input  logic clk,
    input  logic rst_n,
    input  logic run,
    input  logic wide,
    input  logic tick_in,
    output logic bclk_o,
    output logic bclk_rise_o
);
    localparam int DW = $clog2(NARROW_DIV) + 1;

    logic [DW-1:0] ratio;
    logic [DW-1:0] dcnt;

    // Purpose: select the master-to-bit clock ratio.
    always_comb begin
        ratio = wide ? DW'(WIDE_DIV) : DW'(NARROW_DIV);
    end

    // Purpose: advance on each master clock rise and shape the bit clock.
    always_ff @(posedge clk) begin
        if (!rst_n || !run) begin
            dcnt        <= '0;
            bclk_o      <= 1'b0;
            bclk_rise_o <= 1'b0;
        end else if (tick_in) begin
            bclk_o      <= (dcnt < (ratio >> 1));
            bclk_rise_o <= (dcnt == '0);
            if (dcnt == ratio - DW'(1)) begin
                dcnt <= '0;
            end else begin
                dcnt <= dcnt + DW'(1);
            end
        end else begin
            bclk_rise_o <= 1'b0;
        end
    end

endmodule

// File: rtl/audclk_framer.sv
// Frame counter: counts bit-clock rises and emits a one-cycle strobe at
// the first bit of each frame. Frame length is SLOT_BITS or 2*SLOT_BITS
// per channel, times two channels in I2S or one channel in PCM.
// Assumes: bit_rise is a single-cycle pulse; format stable while run.
module audclk_framer
    import audclk_pkg::*;
#(
    parameter int SLOT_BITS = 16
) (
    input  logic       clk,
    input  logic       rst_n,
    input  logic       run,
    input  frame_fmt_e fmt,
    input  logic       wide,
    input  logic       bit_rise,
    output logic       frame_stb_o
);
    localparam int FW = $clog2(4 * SLOT_BITS) + 1;

    logic [FW-1:0] frame_len;
    logic [FW-1:0] fcnt;

    // Purpose: number of bit clocks per frame.
    always_comb begin
        frame_len = FW'(SLOT_BITS);
        if (wide) begin
            frame_len = frame_len << 1;
        end
        if (fmt == FMT_I2S) begin
            frame_len = frame_len << 1;
        end
    end

    // Purpose: bit position counter and frame-start strobe.
    always_ff @(posedge clk) begin
        if (!rst_n || !run) begin
            fcnt        <= '0;
            frame_stb_o <= 1'b0;
        end else if (bit_rise) begin
            frame_stb_o <= (fcnt == '0);
            if (fcnt == frame_len - FW'(1)) begin
                fcnt <= '0;
            end else begin
                fcnt <= fcnt + FW'(1);
            end
        end else begin
            frame_stb_o <= 1'b0;
        end
    end

endmodule

// File: rtl/audio_clkgen.sv
// Audio serial clock prescaler top: captures the configuration while
// disabled, runs a linear prescaler, and derives master clock, bit clock
// and frame strobe from it.
// Assumes: a single source clock; configuration inputs may change at any
// time but take effect only across a disable.
module audio_clkgen
    import audclk_pkg::*;
#(
    parameter int DIV_W      = 8,
    parameter int SLOT_BITS  = 16,
    parameter int NARROW_DIV = 8,
    parameter int WIDE_DIV   = 4
) (
    input  logic             clk_src,
    input  logic             rst_n,
    input  logic             gen_en,
    input  logic [DIV_W-1:0] div_val,
    input  logic             odd_ext,
    input  logic             mclk_en,
    input  logic             pcm_mode,
    input  logic             chan32,
    output logic             mclk_out,
    output logic             bclk_out,
    output logic             frame_stb
);
    mode_cfg_t        mode_q;
    logic [DIV_W-1:0] div_q;
    logic             pre_clk;
    logic             pre_rise;
    logic             bd_bclk;
    logic             bd_rise;
    logic             bit_rise;
    logic             bd_run;

    // Purpose: sample the configuration only while the generator is idle.
    always_ff @(posedge clk_src) begin
        if (!rst_n) begin
            mode_q <= '{fmt: FMT_I2S, wide: 1'b0, mclk_on: 1'b0, odd: 1'b0};
            div_q  <= '0;
        end else if (!gen_en) begin
            mode_q <= '{fmt: frame_fmt_e'(pcm_mode), wide: chan32,
                        mclk_on: mclk_en, odd: odd_ext};
            div_q  <= div_val;
        end
    end

    audclk_prescaler #(
        .DIV_W (DIV_W)
    ) u_pre (
        .clk       (clk_src),
        .rst_n     (rst_n),
        .run       (gen_en),
        .div       (div_q),
        .odd       (mode_q.odd),
        .pre_clk_o (pre_clk),
        .rise_o    (pre_rise)
    );

    // Purpose: the bit divider runs only when the master clock is driven.
    always_comb begin
        bd_run = gen_en && mode_q.mclk_on;
    end

    audclk_bitdiv #(
        .NARROW_DIV (NARROW_DIV),
        .WIDE_DIV   (WIDE_DIV)
    ) u_bit (
        .clk         (clk_src),
        .rst_n       (rst_n),
        .run         (bd_run),
        .wide        (mode_q.wide),
        .tick_in     (pre_rise),
        .bclk_o      (bd_bclk),
        .bclk_rise_o (bd_rise)
    );

    // Purpose: route prescaler output to master or bit clock by mode.
    always_comb begin
        if (mode_q.mclk_on) begin
            mclk_out = pre_clk;
            bclk_out = bd_bclk;
            bit_rise = bd_rise;
        end else begin
            mclk_out = 1'b0;
            bclk_out = pre_clk;
            bit_rise = pre_rise;
        end
    end

    audclk_framer #(
        .SLOT_BITS (SLOT_BITS)
    ) u_frm (
        .clk         (clk_src),
        .rst_n       (rst_n),
        .run         (gen_en),
        .fmt         (mode_q.fmt),
        .wide        (mode_q.wide),
        .bit_rise    (bit_rise),
        .frame_stb_o (frame_stb)
    );

endmodule

// File: rtl/audclk_checker.sv
// Property checker for audio_clkgen, attached by bind below.
// Assumes: connected to the top's captured configuration registers.
module audclk_checker
    import audclk_pkg::*;
#(
    parameter int DIV_W = 8
) (
    input logic             clk_src,
    input logic             rst_n,
    input logic             gen_en,
    input logic             mclk_out,
    input logic             bclk_out,
    input logic             frame_stb,
    input mode_cfg_t        cfg_mode,
    input logic [DIV_W-1:0] cfg_div
);
    logic        seen;
    logic [15:0] hi_run;
    logic [15:0] exp_hi;
    logic [15:0] per_n;

    // Purpose: mark that at least one edge has passed since reset.
    always_ff @(posedge clk_src) begin
        if (!rst_n) begin
            seen <= 1'b0;
        end else begin
            seen <= 1'b1;
        end
    end

    // Purpose: length of the current master clock high phase.
    always_ff @(posedge clk_src) begin
        if (!rst_n) begin
            hi_run <= '0;
        end else if (mclk_out) begin
            hi_run <= hi_run + 16'd1;
        end else begin
            hi_run <= '0;
        end
    end

    // Purpose: expected high phase from the captured divider setting.
    always_comb begin
        per_n  = (cfg_div < DIV_W'(2)) ? 16'd2
                 : (16'(cfg_div) * 16'd2 + 16'(cfg_mode.odd));
        exp_hi = per_n - (per_n >> 1);
    end

    a_r1_idle_quiet: assert property (@(posedge clk_src) disable iff (!rst_n)
        !gen_en |=> (!mclk_out && !bclk_out && !frame_stb));

    a_r3_mclk_high_len: assert property (@(posedge clk_src) disable iff (!rst_n)
        (seen && gen_en && $past(gen_en) && $fell(mclk_out)) |-> (hi_run == exp_hi));

    a_r9_strobe_single: assert property (@(posedge clk_src) disable iff (!rst_n)
        frame_stb |=> !frame_stb);

    a_r10_cfg_frozen: assert property (@(posedge clk_src) disable iff (!rst_n)
        (seen && gen_en && $past(gen_en)) |-> ($stable(cfg_mode) && $stable(cfg_div)));

endmodule

bind audio_clkgen audclk_checker #(.DIV_W(DIV_W)) u_chk (
    .clk_src   (clk_src),
    .rst_n     (rst_n),
    .gen_en    (gen_en),
    .mclk_out  (mclk_out),
    .bclk_out  (bclk_out),
    .frame_stb (frame_stb),
    .cfg_mode  (mode_q),
    .cfg_div   (div_q)
);

// File: tb/sim_audio_clkgen.sv
module sim_audio_clkgen;
    localparam int CLK_PERIOD = 10;
    localparam int DIV_W      = 8;

    logic             clk_src = 1'b0;
    logic             rst_n   = 1'b0;
    logic             gen_en  = 1'b0;
    logic [DIV_W-1:0] div_val = '0;
    logic             odd_ext = 1'b0;
    logic             mclk_en = 1'b0;
    logic             pcm_mode = 1'b0;
    logic             chan32  = 1'b0;
    logic             mclk_out;
    logic             bclk_out;
    logic             frame_stb;

    int checks   = 0;
    int failures = 0;

    always #(CLK_PERIOD / 2) clk_src = ~clk_src;

    audio_clkgen #(.DIV_W(DIV_W)) u0 (
        .clk_src   (clk_src),
        .rst_n     (rst_n),
        .gen_en    (gen_en),
        .div_val   (div_val),
        .odd_ext   (odd_ext),
        .mclk_en   (mclk_en),
        .pcm_mode  (pcm_mode),
        .chan32    (chan32),
        .mclk_out  (mclk_out),
        .bclk_out  (bclk_out),
        .frame_stb (frame_stb)
    );

    task automatic chk(input string req, input int act, input int exp);
        checks++;
        if (act != exp) begin
            failures++;
            $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
        end
    endtask

    function automatic logic pick(input int w);
        case (w)
            0:       return mclk_out;
            1:       return bclk_out;
            default: return frame_stb;
        endcase
    endfunction

    // Measure one full period and its high time of output w, from a rise
    // to the next rise, sampling at falling edges of the source clock.
    task automatic meas(input int w, output int per, output int hi);
        logic prev;
        logic cur;
        int   guard;
        prev  = pick(w);
        guard = 0;
        per   = -1;
        hi    = -1;
        forever begin
            @(negedge clk_src);
            cur = pick(w);
            guard++;
            if (!prev && cur) break;
            prev = cur;
            if (guard > 20000) return;
        end
        per  = 1;
        hi   = 1;
        prev = 1'b1;
        forever begin
            @(negedge clk_src);
            cur = pick(w);
            if (!prev && cur) break;
            per++;
            if (cur) hi++;
            prev = cur;
            if (per > 20000) return;
        end
    endtask

    task automatic start_cfg(input int d, input logic o, input logic m,
                             input logic p, input logic c);
        @(negedge clk_src);
        gen_en   = 1'b0;
        div_val  = DIV_W'(d);
        odd_ext  = o;
        mclk_en  = m;
        pcm_mode = p;
        chan32   = c;
        @(negedge clk_src);
        @(negedge clk_src);
        gen_en = 1'b1;
    endtask

    task automatic idle_check(input string tag);
        for (int i = 0; i < 4; i++) begin
            @(negedge clk_src);
            chk(tag, int'({mclk_out, bclk_out, frame_stb}), 0);
        end
    endtask

    initial begin
        #(CLK_PERIOD * 190000);
        failures++;
        $display("FAIL watchdog actual=timeout expected=completion");
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end

    initial begin
        int per;
        int hi;
        int n;
        int bper;
        int fper;
        int divs[5] = '{0, 1, 2, 3, 4};

        // R1: reset state
        mclk_en = 1'b1;
        gen_en  = 1'b1;
        idle_check("R1 reset");
        @(negedge clk_src);
        rst_n  = 1'b1;
        gen_en = 1'b0;
        idle_check("R1 disabled");

        for (int di = 0; di < 5; di++) begin
            for (int o = 0; o < 2; o++) begin
                for (int m = 0; m < 2; m++) begin
                    for (int p = 0; p < 2; p++) begin
                        for (int c = 0; c < 2; c++) begin
                            start_cfg(divs[di], o[0], m[0], p[0], c[0]);
                            // R2/R4: prescaler period
                            n = (divs[di] < 2) ? 2 : 2 * divs[di] + o;
                            if (m == 1) begin
                                meas(0, per, hi);
                                chk(divs[di] < 2 ? "R4 mclk period" : "R2 mclk period", per, n);
                                chk("R3 mclk high", hi, n - n / 2);
                                bper = (c == 1) ? 4 * n : 8 * n;
                                meas(1, per, hi);
                                chk("R5 bclk period", per, bper);
                                chk("R5 bclk high", hi, bper / 2);
                                fper = (p == 1) ? 128 * n : 256 * n;
                                meas(2, per, hi);
                                chk("R7 frame period", per, fper);
                                chk("R9 strobe width", hi, 1);
                            end else begin
                                meas(1, per, hi);
                                chk("R6 bclk period", per, n);
                                chk("R6 bclk high", hi, n - n / 2);
                                chk("R6 mclk parked", int'(mclk_out), 0);
                                fper = ((p == 1) ? 16 : 32) * (c + 1) * n;
                                meas(2, per, hi);
                                chk("R8 frame period", per, fper);
                                chk("R9 strobe width", hi, 1);
                                chk("R6 mclk parked", int'(mclk_out), 0);
                            end
                        end
                    end
                end
            end
        end

        // R10: change divider while running, old period must remain
        start_cfg(3, 1'b0, 1'b1, 1'b0, 1'b0);
        meas(0, per, hi);
        chk("R10 base period", per, 6);
        @(negedge clk_src);
        div_val = DIV_W'(5);
        odd_ext = 1'b1;
        mclk_en = 1'b0;
        meas(0, per, hi);
        chk("R10 period held", per, 6);
        meas(0, per, hi);
        chk("R10 period held", per, 6);
        @(negedge clk_src);
        gen_en = 1'b0;
        idle_check("R1 after disable");
        start_cfg(5, 1'b1, 1'b1, 1'b0, 1'b0);
        meas(0, per, hi);
        chk("R10 new period", per, 11);
        chk("R3 odd high", hi, 6);

        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end

endmodule